// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block serves a translation miss. It takes a 32-bit virtual address and the current root-table pointer, then reads the page table from memory in two dependent steps. The first read fetches a root-level entry. The second read fetches a leaf entry from the table that the root entry names. The walk ends in one of two ways. Either it returns a physical frame number with its read, write and execute rights, ready to be loaded into a TLB, or it reports a page fault and the level at which the fault occurred.

The address is split 10/10/12. The upper ten bits index the root table. The middle ten bits index the leaf table. The low twelve bits are the page offset, which the walker does not use. Every entry is one 32-bit word, so each table of 1024 entries fills one 4 KB page. The root pointer is sampled when a walk is accepted, so software may load a new pointer between walks, for example on a context switch. Memory is reached through a simple request/response port, and a response may arrive any number of cycles after its request is accepted.

Top module: `pt_walk_unit`

## Requirements
- R1: After reset, walk_ready is 1 and both mem_req_valid and done are 0.
- R2: The first memory read of a walk goes to root_base + 4 * walk_vaddr[31:22], using the values sampled when the walk was accepted.
- R3: The second memory read goes to (root entry bits [31:12]) * 4096 + 4 * walk_vaddr[21:12].
- R4: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr does not change.
- R5: A root entry whose bit 0 (valid) is 0 ends the walk with done=1, fault=1 and fault_level=0, and no second read is issued.
- R6: A leaf entry whose bit 0 is 0 ends the walk with done=1, fault=1 and fault_level=1.
- R7: A valid leaf entry ends the walk with done=1 and fault=0. res_frame holds the leaf entry bits [31:12], and res_perm = {execute, write, read} = leaf entry bits [3:1].
- R8: done is high for exactly one cycle per walk, and fault is high only while done is high.
- R9: A walk is accepted only when walk_ready is 1, and walk_ready is 0 from acceptance until the walk ends. A walk_valid, address or root change during a walk has no effect on that walk's reads or result and starts no further walk.
- R10: A new root_base given with a later walk is used for that walk, so the same virtual address can resolve to a different frame.
- R11: Any number of stall cycles on mem_req_ready and any number of wait cycles before mem_rsp_valid are tolerated. The walker waits in place and produces the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Request to start a walk |
| walk_ready | output | 1 | Walker idle and able to accept a walk |
| walk_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the root table |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| done | output | 1 | One-cycle pulse marking the end of a walk |
| fault | output | 1 | Walk ended in a page fault (valid with done) |
| fault_level | output | 1 | 0: root entry invalid, 1: leaf entry invalid |
| res_frame | output | 20 | Physical frame number (valid with done and not fault) |
| res_perm | output | 3 | {execute, write, read} rights of the leaf entry |

## Verification
The bench aims at the two fault exits. A walker that skipped the validity check on the root entry would issue a second read to a garbage table, and one that mislabelled the level would blame the wrong table. Both show up in the recorded read addresses and in fault_level. Long memory stalls and slow responses are mixed with short ones, which exposes a walker that drops its request or moves its address before acceptance. A foreign request with a different address and root is injected during a busy walk, which exposes a walker that re-samples its inputs mid-walk or starts a phantom walk. The same virtual address is walked under two root pointers to catch a stale root.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PERM_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5,
        ST_FAULT   = 3'd6
    } walk_state_t;

    typedef enum logic {
        LVL_ROOT = 1'b0,
        LVL_LEAF = 1'b1
    } walk_level_t;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W   = 32,
    parameter int FRAME_W = 20
) (
    input  logic [PTE_W-1:0]   pte,
    output logic               pte_valid,
    output logic [FRAME_W-1:0] pte_frame,
    output logic [PERM_W-1:0]  pte_perm
);
    localparam int LOW_W = PTE_W - FRAME_W;
    localparam int FLAG_W = PERM_W + 1;

    assign pte_valid = pte[0];
    assign pte_perm  = pte[FLAG_W-1:1];
    assign pte_frame = pte[PTE_W-1 -: FRAME_W];

    generate
        if (LOW_W > FLAG_W) begin : g_rsvd
            logic unused_rsvd_bits;
            assign unused_rsvd_bits = ^pte[LOW_W-1:FLAG_W];
        end
    endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W           = 32,
    parameter int PA_W           = 32,
    parameter int OFF_W          = 12,
    parameter int IDX_W          = 10,
    parameter int ENT_BYTES_LOG2 = 2
) (
    input  logic [VA_W-1:0]         vaddr,
    input  logic [PA_W-1:0]         root,
    input  logic [PA_W-OFF_W-1:0]   l1_frame,
    input  logic                    leaf_sel,
    output logic [PA_W-1:0]         entry_addr
);
    localparam int FRAME_W = PA_W - OFF_W;

    logic [IDX_W-1:0] idx_root;
    logic [IDX_W-1:0] idx_leaf;
    logic [PA_W-1:0]  off_root;
    logic [PA_W-1:0]  off_leaf;
    logic [PA_W-1:0]  leaf_base;
    logic             unused_page_offset;

    assign idx_root  = vaddr[OFF_W+IDX_W +: IDX_W];
    assign idx_leaf  = vaddr[OFF_W +: IDX_W];
    assign leaf_base = {l1_frame, {OFF_W{1'b0}}};
    assign unused_page_offset = ^vaddr[OFF_W-1:0];

    generate
        if (ENT_BYTES_LOG2 > 0) begin : g_scaled
            assign off_root = PA_W'({idx_root, {ENT_BYTES_LOG2{1'b0}}});
            assign off_leaf = PA_W'({idx_leaf, {ENT_BYTES_LOG2{1'b0}}});
        end else begin : g_bytewide
            assign off_root = PA_W'(idx_root);
            assign off_leaf = PA_W'(idx_leaf);
        end
        if (VA_W > OFF_W + 2*IDX_W) begin : g_va_top
            logic unused_va_top;
            assign unused_va_top = ^vaddr[VA_W-1:OFF_W+2*IDX_W];
        end
    endgenerate

    always_comb begin
        if (leaf_sel) begin
            entry_addr = leaf_base + off_leaf;
        end else begin
            entry_addr = root + off_root;
        end
    end

endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit
    import ptw_pkg::*;
#(
    parameter int VA_W           = 32,
    parameter int PA_W           = 32,
    parameter int OFF_W          = 12,
    parameter int IDX_W          = 10,
    parameter int ENT_BYTES_LOG2 = 2,
    parameter int PTE_W          = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      walk_valid,
    output logic                      walk_ready,
    input  logic [VA_W-1:0]           walk_vaddr,
    input  logic [PA_W-1:0]           root_base,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic [PA_W-1:0]           mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [PTE_W-1:0]          mem_rsp_data,
    output logic                      done,
    output logic                      fault,
    output logic                      fault_level,
    output logic [PA_W-OFF_W-1:0]     res_frame,
    output logic [PERM_W-1:0]         res_perm
);
    localparam int FRAME_W = PA_W - OFF_W;

    typedef struct packed {
        walk_state_t        st;
        logic [VA_W-1:0]    va;
        logic [PA_W-1:0]    root;
        logic [FRAME_W-1:0] frame;
        logic [PERM_W-1:0]  perm;
        walk_level_t        flvl;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic               pte_valid;
    logic [FRAME_W-1:0] pte_frame;
    logic [PERM_W-1:0]  pte_perm;
    logic               leaf_sel;

    ptw_pte_decode #(
        .PTE_W   (PTE_W),
        .FRAME_W (FRAME_W)
    ) u_decode (
        .pte       (mem_rsp_data),
        .pte_valid (pte_valid),
        .pte_frame (pte_frame),
        .pte_perm  (pte_perm)
    );

    assign leaf_sel = (walk_q.st == ST_L2_REQ);

    ptw_addr_gen #(
        .VA_W           (VA_W),
        .PA_W           (PA_W),
        .OFF_W          (OFF_W),
        .IDX_W          (IDX_W),
        .ENT_BYTES_LOG2 (ENT_BYTES_LOG2)
    ) u_addr (
        .vaddr      (walk_q.va),
        .root       (walk_q.root),
        .l1_frame   (walk_q.frame),
        .leaf_sel   (leaf_sel),
        .entry_addr (mem_req_addr)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (walk_valid) begin
                    walk_d.st   = ST_L1_REQ;
                    walk_d.va   = walk_vaddr;
                    walk_d.root = root_base;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_L1_WAIT;
                end
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (pte_valid) begin
                        walk_d.frame = pte_frame;
                        walk_d.st    = ST_L2_REQ;
                    end else begin
                        walk_d.flvl = LVL_ROOT;
                        walk_d.perm = '0;
                        walk_d.st   = ST_FAULT;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_L2_WAIT;
                end
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (pte_valid) begin
                        walk_d.frame = pte_frame;
                        walk_d.perm  = pte_perm;
                        walk_d.st    = ST_DONE;
                    end else begin
                        walk_d.flvl = LVL_LEAF;
                        walk_d.perm = '0;
                        walk_d.st   = ST_FAULT;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                walk_d.st = ST_IDLE;
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign walk_ready    = (walk_q.st == ST_IDLE);
    assign mem_req_valid = (walk_q.st == ST_L1_REQ) || (walk_q.st == ST_L2_REQ);
    assign done          = (walk_q.st == ST_DONE) || (walk_q.st == ST_FAULT);
    assign fault         = (walk_q.st == ST_FAULT);
    assign fault_level   = walk_q.flvl;
    assign res_frame     = walk_q.frame;
    assign res_perm      = walk_q.perm;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> walk_ready && !mem_req_valid && !done); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_FAULT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done) |-> !walk_ready); // R9

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ready && walk_valid |=> mem_req_valid && !walk_ready); // R9

endmodule

// File: tb/tb_pt_walk_unit.sv
`timescale 1ns/1ps
module tb_pt_walk_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [31:0] walk_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic        fault_level;
    logic [19:0] res_frame;
    logic [2:0]  res_perm;

    always #2.5 clk = ~clk;

    pt_walk_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .walk_valid    (walk_valid),
        .walk_ready    (walk_ready),
        .walk_vaddr    (walk_vaddr),
        .root_base     (root_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fault         (fault),
        .fault_level   (fault_level),
        .res_frame     (res_frame),
        .res_perm      (res_perm)
    );

    typedef struct {
        bit        fault;
        bit        lvl;
        bit [19:0] frame;
        bit [2:0]  perm;
        int        nreads;
        bit [31:0] a1;
        bit [31:0] a2;
        string     tag;
    } exp_t;

    exp_t        sb_q[$];
    bit [31:0]   addr_log[$];
    bit [31:0]   mem [bit [31:0]];
    int          n_checks = 0;
    int          n_fails = 0;
    int          extra_lat = 0;
    int          extra_stall = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory responder: random-ish stalls and latencies, records accepted addresses
    initial begin : responder
        bit        busy = 0;
        bit        seen = 0;
        bit        moved = 0;
        int        lat_left = 0;
        int        stall_left = 0;
        int        rseq = 0;
        bit [31:0] held = 0;
        bit [31:0] rsp_word = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (busy) begin
                mem_req_ready = 1'b0;
                if (lat_left == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_word;
                    busy = 0;
                end else begin
                    lat_left--;
                end
            end else if (rst_n && mem_req_valid) begin
                if (!seen) begin
                    seen = 1;
                    moved = 0;
                    held = mem_req_addr;
                    rseq++;
                    stall_left = (rseq % 3) + extra_stall;
                end else if (mem_req_addr != held) begin
                    moved = 1;
                end
                if (stall_left > 0) begin
                    stall_left--;
                    mem_req_ready = 1'b0;
                end else begin
                    mem_req_ready = 1'b1;
                    check(!moved && mem_req_addr == held, "R4", "request address moved while stalled",
                          mem_req_addr, held);
                    addr_log.push_back(mem_req_addr);
                    rsp_word = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                    lat_left = (rseq % 4) + extra_lat;
                    busy = 1;
                    seen = 0;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    // Monitor: pops expected results and compares when done is seen
    initial begin : monitor
        bit prev_done = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) begin
                    check(!done, "R8", "done longer than one cycle", done, 0);
                    prev_done = 0;
                end else if (done) begin
                    prev_done = 1;
                    if (sb_q.size() == 0) begin
                        check(0, "R9", "done with no walk outstanding", 1, 0);
                    end else begin
                        e = sb_q.pop_front();
                        check(addr_log.size() == e.nreads, e.fault && !e.lvl ? "R5" : "R3",
                              {e.tag, " read count"}, addr_log.size(), e.nreads);
                        if (addr_log.size() >= 1)
                            check(addr_log[0] == e.a1, "R2", {e.tag, " root read address"},
                                  addr_log[0], e.a1);
                        if (addr_log.size() >= 2 && e.nreads == 2)
                            check(addr_log[1] == e.a2, "R3", {e.tag, " leaf read address"},
                                  addr_log[1], e.a2);
                        check(fault == e.fault, e.fault ? (e.lvl ? "R6" : "R5") : "R7",
                              {e.tag, " fault flag"}, fault, e.fault);
                        if (e.fault) begin
                            check(fault_level == e.lvl, e.lvl ? "R6" : "R5",
                                  {e.tag, " fault level"}, fault_level, e.lvl);
                        end else begin
                            check(res_frame == e.frame, "R7", {e.tag, " frame"}, res_frame, e.frame);
                            check(res_perm == e.perm, "R7", {e.tag, " permissions"}, res_perm, e.perm);
                        end
                    end
                    addr_log.delete();
                end
            end
        end
    end

    task automatic do_walk(input bit [31:0] va, input bit [31:0] base,
                           input bit [31:0] l1e, input bit [31:0] l2e,
                           input string tag, input bit noise);
        exp_t e;
        e.tag = tag;
        e.a1 = base + {20'h0, va[31:22], 2'b00};
        e.a2 = 0;
        e.frame = 0;
        e.perm = 0;
        e.lvl = 0;
        mem[e.a1] = l1e;
        if (!l1e[0]) begin
            e.fault = 1; e.lvl = 0; e.nreads = 1;
        end else begin
            e.a2 = {l1e[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
            mem[e.a2] = l2e;
            e.nreads = 2;
            if (!l2e[0]) begin
                e.fault = 1; e.lvl = 1;
            end else begin
                e.fault = 0; e.frame = l2e[31:12]; e.perm = l2e[3:1];
            end
        end
        sb_q.push_back(e);
        @(negedge clk);
        walk_valid = 1'b1;
        walk_vaddr = va;
        root_base  = base;
        while (!walk_ready) @(negedge clk);
        @(negedge clk);
        walk_valid = 1'b0;
        if (noise) begin
            // R9: foreign request with other inputs while busy
            check(!walk_ready, "R9", "ready while walk in progress", walk_ready, 0);
            walk_valid = 1'b1;
            walk_vaddr = ~va;
            root_base  = base + 32'h0000_1000;
            @(negedge clk);
            @(negedge clk);
            walk_valid = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (noise) begin
            check(walk_ready && !mem_req_valid, "R9", "extra walk after busy request",
                  {walk_ready, mem_req_valid}, 2'b10);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(walk_ready == 1'b1, "R1", "walk_ready in reset", walk_ready, 1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_walk(32'h1234_5678, 32'h0040_0000, 32'h0008_0001, 32'h000A_B00F, "R7 full rights", 0);
        do_walk(32'h8000_1000, 32'h0040_0000, 32'h0009_000E, 32'h0, "R5 root invalid", 0);
        do_walk(32'h0040_3000, 32'h0040_0000, 32'h0009_1001, 32'h000C_000E, "R6 leaf invalid", 0);
        do_walk(32'h1000_2000, 32'h0050_0000, 32'h0007_0001, 32'h0001_1003, "R10 root A", 0);
        do_walk(32'h1000_2000, 32'h0060_0000, 32'h0007_1001, 32'h0002_2005, "R10 root B", 0);
        do_walk(32'hABCD_E123, 32'h0040_0000, 32'h0009_3001, 32'h0003_3009, "R9 busy request", 1);
        extra_lat = 25;
        extra_stall = 10;
        do_walk(32'h0000_0000, 32'h0070_0000, 32'h0009_4001, 32'h0FFF_F007, "R11 slow memory", 0);
        do_walk(32'h7FF0_0000, 32'h0070_0000, 32'h0009_5000, 32'h0, "R11 slow root fault", 0);
        extra_lat = 0;
        extra_stall = 0;
        do_walk(32'hFFFF_FFFF, 32'h0000_1000, 32'hFFFF_F001, 32'h1234_5003, "R2 top address", 0);
        do_walk(32'h0000_0FFF, 32'h0080_0000, 32'h0009_6001, 32'h0005_500D, "R7 write exec", 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule